// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a synchronous on-chip bus and an external pseudo-static RAM that has an SRAM-style asynchronous pinout: a 21-bit word address, a 16-bit data bus and two byte strobes. The bus side hands it one access at a time. Each access is a read or a write of a single word, with one enable bit per byte, and is offered on a valid/ready handshake. The controller then plays out the pin sequence for that access. Every analog minimum is converted into a whole number of system clock cycles, and the clock period and the nanosecond figures are parameters.

Reads return the word on a one-cycle response strobe. A byte lane that was not enabled reads back as zero. The data bus is split into an output value, an input value and a drive enable. The controller never drives the bus while the memory may be driving it, and a turnaround cycle is kept on each side. Chip enable is released after every access. This keeps each selected period short and far under the device's maximum active time, so the memory's internal refresh always gets a full cycle.

Top module: `psram_ctrl`

## Requirements
- R1: Coming out of reset, chip enable, output enable, write enable and both byte strobes (all active low) are high, the data drive enable is low, req_ready is high and rsp_valid is low. The active-high chip select is high after reset. Chip enable is low only while chip select is high.
- R2: A read holds chip enable and output enable low and write enable high for NRD+1 cycles, where NRD = ceil(max(75 ns access, 75 ns read cycle)/period). Data on mem_dq_in is captured at the end of that last cycle. rsp_valid pulses for one cycle, NRD+2 cycles after the accepting edge.
- R3: Byte-enable bit 0 maps to the lower strobe (data bits 7:0) and bit 1 maps to the upper strobe (bits 15:8). A strobe is low during an access exactly when its enable bit is 1. Read data in a lane that was not enabled is returned as zero.
- R4: A write drops chip enable and write enable together, in the cycle the address is presented. Write enable stays low, with the data driven, for NWP = ceil(max(50, 60, 60, 30 ns)/period) cycles. Chip enable then stays high for enough cycles that the address is held at least ceil(75 ns/period) cycles in total.
- R5: A write changes only the enabled byte lanes of the addressed word. A write with no lanes enabled leaves the word unchanged.
- R6: Output enable is high in every cycle in which write enable is low or the data drive enable is high.
- R7: Output enable falls only after the drive enable has been low for at least one cycle. The drive enable rises only after output enable has been high for at least one cycle.
- R8: Chip enable is high for at least one cycle between accesses. The address does not change while chip enable stays low.
- R9: Chip enable is never low for more than floor(10 us/period) consecutive cycles.
- R10: req_ready is high only when no access is in progress. A request is taken on a cycle in which both req_valid and req_ready are high. rsp_valid is raised only for reads, once per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | 21 | Memory address |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Two things can happen in the same cycle. A response goes out on rsp_valid while the next request is already waiting on req_valid, and the bus has to turn around between a write and the read that follows it. The bench provokes both by keeping req_valid high with randomly mixed reads and writes, so each access is offered the moment the previous one ends. The response is judged against a reference word and an expected latency. A pin monitor in the bench checks the turnaround ordering, the chip-enable gap and contention freedom at the same time. Its memory model delivers correct data only after the full access window, so a capture that comes too early returns a wrong word.

// File: rtl/psram_ctrl_pkg.sv
// Package: shared state type, pin bundle and cycle-count helpers for
// the pseudo-static RAM controller. Assumes positive integer inputs.
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_CAP,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_GAP
    } pctl_state_t;

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic       we_n;
        logic       dq_oe;
        logic [1:0] strb_n;
    } pctl_pins_t;

    // Round a nanosecond minimum up to clock cycles, never below one.
    function automatic int pc_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int pc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
// Loadable down-counter that times each phase of an access.
// Assumes load has priority; zero is reported while the count is 0.
module psram_cycle_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reloading whenever a phase starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_lane_ctrl.sv
// Maps byte enables to active-low lane strobes and a read-data mask.
// Assumes DATA_W is a multiple of 8, one enable bit per byte.
module psram_lane_ctrl #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  be,
    output logic [LANES-1:0]  strb_n,
    output logic [DATA_W-1:0] mask
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One strobe and one 8-bit mask slice per byte lane.
        assign strb_n[g]         = ~be[g];
        assign mask[g*8 +: 8]    = {8{be[g]}};
    end

endmodule

// File: rtl/psram_ctrl.sv
// Top: single-word access controller for an asynchronous SRAM-pinout
// pseudo-static RAM. Converts nanosecond minimums into clock counts,
// registers every memory pin, releases chip enable after each access
// and keeps a one-cycle bus turnaround on both sides of output enable.
// Assumes DATA_W = 16 (two lanes) and one access in flight at a time.
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int CLK_NS      = 10,
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 16,
    parameter int T_ACC_NS    = 75,
    parameter int T_RC_NS     = 75,
    parameter int T_WC_NS     = 75,
    parameter int T_WP_NS     = 50,
    parameter int T_CW_NS     = 60,
    parameter int T_AW_NS     = 60,
    parameter int T_DS_NS     = 30,
    parameter int T_CEH_NS    = 10,
    parameter int T_MAXSEL_NS = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int N_RD    = pc_max(pc_cycles(T_ACC_NS, CLK_NS), pc_cycles(T_RC_NS, CLK_NS));
    localparam int N_WP    = pc_max(pc_max(pc_cycles(T_WP_NS, CLK_NS), pc_cycles(T_CW_NS, CLK_NS)),
                                    pc_max(pc_cycles(T_AW_NS, CLK_NS), pc_cycles(T_DS_NS, CLK_NS)));
    localparam int N_WC    = pc_cycles(T_WC_NS, CLK_NS);
    localparam int N_WREC  = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
    localparam int N_GAP   = pc_cycles(T_CEH_NS, CLK_NS);
    localparam int MAX_SEL = T_MAXSEL_NS / CLK_NS;
    localparam int CNT_W   = $clog2(pc_max(MAX_SEL, pc_max(N_RD, N_WP) + N_WREC + N_GAP) + 2);

    pctl_state_t       state_q, state_d;
    pctl_pins_t        pins_q, pins_d;
    logic              t_load, t_zero;
    logic [CNT_W-1:0]  t_val;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rmask;
    logic [1:0]        be_q, be_nx, strb_nx;
    logic              cs_q, rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign be_nx     = accept ? req_be : be_q;

    psram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    psram_lane_ctrl #(.DATA_W(DATA_W)) u_lanes (
        .be     (be_nx),
        .strb_n (strb_nx),
        .mask   (rmask)
    );

    // Phase sequencing: pick the next state and the length of its phase.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = req_write ? ST_WR_PULSE : ST_RD_ACC;
                t_load  = 1'b1;
                t_val   = req_write ? CNT_W'(N_WP - 1) : CNT_W'(N_RD - 1);
            end
            ST_RD_ACC: if (t_zero) state_d = ST_RD_CAP;
            ST_RD_CAP: begin
                state_d = ST_GAP;
                t_load  = 1'b1;
                t_val   = CNT_W'(N_GAP - 1);
            end
            ST_WR_PULSE: if (t_zero) begin
                state_d = ST_WR_REC;
                t_load  = 1'b1;
                t_val   = CNT_W'(N_WREC - 1);
            end
            ST_WR_REC: if (t_zero) begin
                state_d = ST_GAP;
                t_load  = 1'b1;
                t_val   = CNT_W'(N_GAP - 1);
            end
            ST_GAP: if (t_zero) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin levels for the state about to be entered, so pins are registered.
    always_comb begin
        pins_d = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, strb_n: 2'b11};
        unique case (state_d)
            ST_RD_ACC, ST_RD_CAP: begin
                pins_d.ce_n   = 1'b0;
                pins_d.oe_n   = 1'b0;
                pins_d.strb_n = strb_nx;
            end
            ST_WR_PULSE: begin
                pins_d.ce_n   = 1'b0;
                pins_d.we_n   = 1'b0;
                pins_d.dq_oe  = 1'b1;
                pins_d.strb_n = strb_nx;
            end
            default: ;
        endcase
    end

    // State, pin and request-latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pins_q  <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, strb_n: 2'b11};
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_d;
            cs_q    <= 1'b1;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end

    // Read capture at the end of the extra sample cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= (state_q == ST_RD_CAP);
            if (state_q == ST_RD_CAP)
                rsp_rdata_q <= mem_dq_in & rmask;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign mem_ce_n   = pins_q.ce_n;
    assign mem_cs     = cs_q;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_we_n   = pins_q.we_n;
    assign mem_dq_oe  = pins_q.dq_oe;
    assign mem_lb_n   = pins_q.strb_n[0];
    assign mem_ub_n   = pins_q.strb_n[1];
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] sel_run_q, we_run_q;

    // Run lengths of chip-enable-low and write-enable-low, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_run_q <= '0;
            we_run_q  <= '0;
        end else begin
            sel_run_q <= mem_ce_n ? '0 : sel_run_q + 1'b1;
            we_run_q  <= mem_we_n ? '0 : we_run_q + 1'b1;
        end
    end

    a_r1_sel_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> mem_cs);

    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q >= CNT_W'(N_WP)));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe || !mem_we_n) |-> mem_oe_n);

    a_r7_oe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    a_r7_drive_after_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r9_max_select: assert property (@(posedge clk) disable iff (!rst_n)
        sel_run_q <= CNT_W'(MAX_SEL));

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_dq_oe == 1'b0));

endmodule

// File: tb/psram_ctrl_bench.sv
module psram_ctrl_bench;

    localparam int CLK_NS  = 20;
    localparam int NRD     = 4;   // ceil(75/20)
    localparam int NWP     = 3;   // ceil(60/20)
    localparam int NWC     = 4;   // ceil(75/20)
    localparam int MAXSEL  = 500; // 10000/20
    localparam int NSLOT   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_cs, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [20:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hDEAD;

    psram_ctrl #(.CLK_NS(CLK_NS)) u_psram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(CLK_NS/2) clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;
    logic [15:0] ref_mem [logic [20:0]];
    logic [15:0] dev_mem [logic [20:0]];
    logic [15:0] exp_q [$];
    int          acc_q [$];
    logic [20:0] slot_addr [NSLOT];
    logic [1:0]  cur_be = '0;
    bit          cur_wr = 0;

    // monitor state
    int rd_cnt = 0, ce_run = 0, we_run = 0;
    logic p_oe_n = 1, p_dq_oe = 0, p_ce_n = 1, p_we_n = 1;
    logic [20:0] p_addr = '0;
    int v_r1 = 0, v_r3 = 0, v_r4 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0;

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model and pin monitor, sampled mid-cycle.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!mem_ce_n && !mem_cs) v_r1++;
            if (!mem_ce_n && ({mem_ub_n, mem_lb_n} != ~cur_be)) v_r3++;
            if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) v_r6++;
            if (!mem_oe_n && p_oe_n && p_dq_oe) v_r7++;
            if (mem_dq_oe && !p_dq_oe && !p_oe_n) v_r7++;
            if (!mem_ce_n && !p_ce_n && mem_addr != p_addr) v_r8++;
            if (!mem_we_n && (mem_ce_n || !mem_dq_oe)) v_r4++;
            if (!mem_we_n && p_we_n && p_ce_n == 1'b0) v_r4++;
            if (mem_we_n && !p_we_n && we_run != NWP) v_r4++;
            if (mem_ce_n && !p_ce_n) begin
                if (ce_run > MAXSEL) v_r9++;
                if (cur_wr && ce_run + 1 < NWP) v_r4++;
            end
            if (mem_ce_n && !p_ce_n && !cur_wr && ce_run != NRD + 1) v_r9++;
            // writes into the model
            if (!mem_ce_n && mem_cs && !mem_we_n) begin
                logic [15:0] w;
                w = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 16'h0;
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                dev_mem[mem_addr] = w;
            end
            // reads: data valid only after the full access window
            if (!mem_ce_n && mem_cs && !mem_oe_n && mem_we_n)
                rd_cnt = (!p_ce_n && mem_addr == p_addr) ? rd_cnt + 1 : 1;
            else
                rd_cnt = 0;
            if (rd_cnt >= NRD + 1) begin
                logic [15:0] d;
                d = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 16'h0;
                mem_dq_in <= {mem_ub_n ? 8'h5A : d[15:8], mem_lb_n ? 8'hA5 : d[7:0]};
            end else
                mem_dq_in <= 16'hDEAD;
            ce_run = mem_ce_n ? 0 : ce_run + 1;
            we_run = mem_we_n ? 0 : we_run + 1;
            p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_ce_n = mem_ce_n;
            p_we_n = mem_we_n; p_addr = mem_addr;
        end
    end

    // Response collector: value and latency of every read (R2, R3, R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0)
                chk(0, "R10", "response without read", 32'(rsp_rdata), 0);
            else begin
                logic [15:0] e;
                int a;
                e = exp_q.pop_front();
                a = acc_q.pop_front();
                chk(rsp_rdata == e, "R2/R3", "read data", 32'(rsp_rdata), 32'(e));
                chk(cyc - a == NRD + 2, "R2", "read latency", 32'(cyc - a), NRD + 2);
            end
        end
    end

    // Offer one request; returns after the accepting edge.
    task automatic issue(input bit wr, input logic [20:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit hold);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        forever begin
            if (req_ready) break;
            @(negedge clk);
        end
        cur_be = be; cur_wr = wr;
        if (wr) begin
            logic [15:0] o;
            o = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
            ref_mem[a] = (o & ~lane_mask(be)) | (d & lane_mask(be));
        end else begin
            logic [15:0] o;
            o = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
            exp_q.push_back(o & lane_mask(be));
        end
        @(posedge clk);
        if (!wr) acc_q.push_back(cyc);
        @(negedge clk);
        if (!hold) req_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R1", "pins in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
        chk(!rsp_valid, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && mem_cs, "R1", "ready and cs after reset", {req_ready, mem_cs}, 2'b11);

        for (int i = 0; i < NSLOT; i++) begin
            slot_addr[i] = {$urandom_range(0, 32'h3FFF), 3'(i % 8)} ^ (21'(i) << 11);
            issue(1, slot_addr[i], 16'($urandom), 2'b11, 0);
            chk(!req_ready, "R10", "busy after accept", 32'(req_ready), 0);
        end
        drain();
        // R4 write pin timing, directed
        issue(1, slot_addr[0], 16'h1234, 2'b11, 0);
        chk(!mem_ce_n && !mem_we_n && mem_dq_oe && mem_dq_out == 16'h1234,
            "R4", "write pulse start", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b001);
        // R5 lane-selective writes
        issue(1, slot_addr[0], 16'hAB00, 2'b10, 0);
        issue(1, slot_addr[0], 16'h00CD, 2'b01, 0);
        issue(1, slot_addr[0], 16'hFFFF, 2'b00, 0);
        issue(0, slot_addr[0], 16'h0, 2'b11, 0);
        drain();
        chk(ref_mem[slot_addr[0]] == 16'hABCD, "R5", "reference merge", 32'(ref_mem[slot_addr[0]]), 16'hABCD);
        // R3 partial reads, lanes zeroed
        issue(0, slot_addr[0], 16'h0, 2'b01, 0);
        chk(!mem_lb_n && mem_ub_n && !mem_oe_n, "R3", "lower strobe only", {mem_ub_n, mem_lb_n}, 2'b10);
        issue(0, slot_addr[0], 16'h0, 2'b10, 0);
        issue(0, slot_addr[0], 16'h0, 2'b00, 0);
        drain();
        // random back-to-back traffic, req_valid held
        for (int i = 0; i < 300; i++) begin
            int s;
            s = $urandom_range(0, NSLOT - 1);
            issue(($urandom % 2) == 1, slot_addr[s], 16'($urandom), 2'($urandom), i != 299);
        end
        drain();
        for (int i = 0; i < NSLOT; i++) issue(0, slot_addr[i], 16'h0, 2'b11, 0);
        drain();
        chk(v_r1 == 0, "R1", "select without cs", v_r1, 0);
        chk(v_r3 == 0, "R3", "strobe mismatch cycles", v_r3, 0);
        chk(v_r4 == 0, "R4", "write timing violations", v_r4, 0);
        chk(v_r6 == 0, "R6", "contention cycles", v_r6, 0);
        chk(v_r7 == 0, "R7", "turnaround violations", v_r7, 0);
        chk(v_r8 == 0, "R8", "address moved while selected", v_r8, 0);
        chk(v_r9 == 0, "R9", "select length violations", v_r9, 0);
        chk(NWC >= NWP, "R4", "cycle constant", NWC, NWP);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule